// File: doc/BRIEF.md
# Multi-Master Cache Maintenance Command Queue

This block sits between several processors and a downstream cache maintenance engine. All processors reach it through one shared register port, and every access carries the ID of the master that makes it. A master builds a command in three shared registers: mode, start address and length. It then reads its own registration-status register. That read submits the command into a small in-order FIFO. The FIFO feeds the engine one command at a time over a valid/done handshake.

Only one master may build a command at a time. The first master to write the mode register locks the shared command registers. It keeps the lock until it reads its own registration status. If another master touches the command registers while the lock is held, that attempt fails, and the failure is recorded for that master. Each master also has its own completion flag, which is set when a command it marked for notification finishes. A separate primitive register accepts a buffer-drain command and reports when the drain is done.

Top module: `maint_queue`

## Requirements
- R1: After reset no master owns the command registers, the queue is empty, `eng_valid_o` is low, and every status read returns 0.
- R2: A write to the mode register (address 0) by a master when no master is the owner makes that master the owner. The mode word holds the operation in bits 1:0 (0 invalidate, 1 clean, 2 flush), the scope in bits 18:17 (1 whole cache, any other value address range) and the notify request in bit 15.
- R3: While the lock is held, a write to mode, start (address 1) or length (address 2) by any other master is dropped and sets that master's bit 0 in its registration status (address 3). That master's status read returns the flag and clears it. Ownership does not change.
- R4: When the owner reads its registration status, the pending command is queued if there is room, the read returns 0, and ownership is released at the same clock edge.
- R5: If the queue holds DEPTH commands when the owner reads its registration status, the read returns bit 1 set. The command is discarded and ownership is still released.
- R6: A repeated mode write by the owner before its status read replaces the pending command, so only one command is queued.
- R7: In whole-cache scope, later start and length writes are ignored, and the engine receives address 0 and length 0.
- R8: `eng_valid_o` is high exactly while the queue is non-empty. The head command stays stable until `eng_done_i` is sampled high, which removes it. Commands reach the engine strictly in the order they were accepted.
- R9: At the edge where a command with notify set completes, bit 2 of its master's completion status (address 4) becomes 1. A command without notify leaves that flag unchanged.
- R10: Writing 1 to bit 2 of completion status clears that master's flag. Writing 0 there has no effect.
- R11: Writing code 0x8 (drain) or 0x9 (prefetch-buffer flush) to the primitive register (address 5) stores the code in read bits 3:0. It also sets the busy bit 31 if the queue is non-empty, and busy stays set until the queue has emptied. Writes of any other code are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 for a write, 0 for a read |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_mid_i | input | MID_W | ID of the accessing master |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as the request |
| eng_valid_o | output | 1 | Head command is presented to the engine |
| eng_op_o | output | 2 | Operation of the head command |
| eng_whole_o | output | 1 | Head command covers the whole cache |
| eng_addr_o | output | 32 | Start address of the head command |
| eng_size_o | output | 32 | Length of the head command |
| eng_mid_o | output | MID_W | Master that issued the head command |
| eng_done_i | input | 1 | Engine has finished the head command |

## Verification
Read data is combinational, so each status value is sampled in the same cycle as its request, a quarter period after the inputs are driven. A submission or a completion takes effect at the next rising edge. The bench reference queue is updated right after that edge, and the engine outputs are compared with the head of the reference queue at every falling edge. This places any error in `eng_valid_o` or the head fields in the exact cycle where it appears. The effects of ownership, full rejection and notification are read back through status registers only after the edge that causes them.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int unsigned AW = 32;

  typedef enum logic [2:0] {
    RA_MODE   = 3'd0,
    RA_START  = 3'd1,
    RA_SIZE   = 3'd2,
    RA_REGST  = 3'd3,
    RA_DONEST = 3'd4,
    RA_PRIM   = 3'd5
  } reg_addr_e;

  localparam int SCOPE_LSB  = 17;
  localparam int NOTIFY_BIT = 15;
  localparam int END_BIT    = 2;
  localparam int BUSY_BIT   = 31;
  localparam logic [3:0] PRIM_DRAIN = 4'h8;
  localparam logic [3:0] PRIM_PFFL  = 4'h9;

  typedef struct packed {
    logic [1:0]    op;
    logic          whole;
    logic          notify;
    logic [AW-1:0] addr;
    logic [AW-1:0] size;
  } cmd_t;
endpackage

// File: rtl/mq_owner.sv
module mq_owner
  import mq_pkg::*;
#(
  parameter int NM = 4,
  parameter int MW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_mode_i,
  input  logic          wr_start_i,
  input  logic          wr_size_i,
  input  logic          rd_stat_i,
  input  logic [MW-1:0] mid_i,
  input  logic [31:0]   wdata_i,
  input  logic          full_i,
  output logic          commit_o,
  output cmd_t          pend_o,
  output logic [1:0]    stat_o
);
  logic          owned_q;
  logic [MW-1:0] owner_q;
  cmd_t          pend_q;
  logic [NM-1:0] fail_q;
  logic          own_hit;
  cmd_t          dec;

  assign own_hit = owned_q && (owner_q == mid_i);

  always_comb begin
    dec        = '0;
    dec.op     = wdata_i[1:0];
    dec.whole  = (wdata_i[SCOPE_LSB+1:SCOPE_LSB] == 2'd1);
    dec.notify = wdata_i[NOTIFY_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owned_q <= 1'b0;
      owner_q <= '0;
      pend_q  <= '0;
      fail_q  <= '0;
    end else begin
      if (wr_mode_i) begin
        if (!owned_q || own_hit) begin
          owned_q <= 1'b1;
          owner_q <= mid_i;
          pend_q  <= dec;  // R6: overwrite, never append
        end else begin
          fail_q[mid_i] <= 1'b1;
        end
      end
      if (wr_start_i || wr_size_i) begin
        if (own_hit) begin
          if (!pend_q.whole) begin  // R7
            if (wr_start_i) pend_q.addr <= wdata_i;
            else            pend_q.size <= wdata_i;
          end
        end else if (owned_q) begin
          fail_q[mid_i] <= 1'b1;
        end
      end
      if (rd_stat_i) begin
        fail_q[mid_i] <= 1'b0;
        if (own_hit) owned_q <= 1'b0;
      end
    end
  end

  assign commit_o = rd_stat_i && own_hit && !full_i;
  assign pend_o   = pend_q;
  assign stat_o   = {own_hit && full_i, fail_q[mid_i]};

  a_r3_owner_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned_q && wr_mode_i && !own_hit) |=> (owned_q && owner_q == $past(owner_q)));
  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && own_hit) |=> !owned_q);
  a_r2_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owned_q && wr_mode_i) |=> (owned_q && owner_q == $past(mid_i)));
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= data_i;
  end

  assign head_o  = mem[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/mq_status.sv
module mq_status #(
  parameter int NM = 4,
  parameter int MW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [MW-1:0] set_mid_i,
  input  logic          clr_i,
  input  logic [MW-1:0] clr_mid_i,
  output logic [NM-1:0] end_o
);
  for (genvar i = 0; i < NM; i++) begin : g_m
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                end_o[i] <= 1'b0;
      else if (set_i && set_mid_i == MW'(i))      end_o[i] <= 1'b1;
      else if (clr_i && clr_mid_i == MW'(i))      end_o[i] <= 1'b0;
    end
  end

  a_r9_end_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> end_o[$past(set_mid_i)]);
endmodule

// File: rtl/maint_queue.sv
module maint_queue
  import mq_pkg::*;
#(
  parameter int NUM_M  = 4,
  parameter int DEPTH  = 4,
  localparam int MID_W = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic [MID_W-1:0] reg_mid_i,
  output logic [31:0]      reg_rdata_o,
  output logic             eng_valid_o,
  output logic [1:0]       eng_op_o,
  output logic             eng_whole_o,
  output logic [AW-1:0]    eng_addr_o,
  output logic [AW-1:0]    eng_size_o,
  output logic [MID_W-1:0] eng_mid_o,
  input  logic             eng_done_i
);
  localparam int EW = MID_W + $bits(cmd_t);

  reg_addr_e ra;
  logic wr, rd;
  logic wr_mode, wr_start, wr_size, rd_stat, wr_done, wr_prim;
  logic commit, full, empty, pop;
  cmd_t pend, head;
  logic [MID_W-1:0] head_mid;
  logic [EW-1:0] head_raw;
  logic [1:0] stat;
  logic [NUM_M-1:0] end_flags;
  logic busy_q;
  logic [3:0] code_q;

  assign ra       = reg_addr_e'(reg_addr_i);
  assign wr       = reg_req_i && reg_we_i;
  assign rd       = reg_req_i && !reg_we_i;
  assign wr_mode  = wr && ra == RA_MODE;
  assign wr_start = wr && ra == RA_START;
  assign wr_size  = wr && ra == RA_SIZE;
  assign rd_stat  = rd && ra == RA_REGST;
  assign wr_done  = wr && ra == RA_DONEST && reg_wdata_i[END_BIT];
  assign wr_prim  = wr && ra == RA_PRIM &&
                    (reg_wdata_i[3:0] == PRIM_DRAIN || reg_wdata_i[3:0] == PRIM_PFFL);

  mq_owner #(.NM(NUM_M), .MW(MID_W)) u_owner (
    .clk_i, .rst_ni,
    .wr_mode_i(wr_mode), .wr_start_i(wr_start), .wr_size_i(wr_size),
    .rd_stat_i(rd_stat), .mid_i(reg_mid_i), .wdata_i(reg_wdata_i),
    .full_i(full), .commit_o(commit), .pend_o(pend), .stat_o(stat)
  );

  mq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(commit), .data_i({reg_mid_i, pend}),
    .pop_i(pop), .head_o(head_raw), .empty_o(empty), .full_o(full)
  );

  assign {head_mid, head} = head_raw;
  assign pop         = eng_done_i && !empty;
  assign eng_valid_o = !empty;
  assign eng_op_o    = head.op;
  assign eng_whole_o = head.whole;
  assign eng_addr_o  = head.addr;
  assign eng_size_o  = head.size;
  assign eng_mid_o   = head_mid;

  mq_status #(.NM(NUM_M), .MW(MID_W)) u_status (
    .clk_i, .rst_ni,
    .set_i(pop && head.notify), .set_mid_i(head_mid),
    .clr_i(wr_done), .clr_mid_i(reg_mid_i), .end_o(end_flags)
  );

  // R11: drain is finished once every queued command has completed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      code_q <= '0;
    end else if (wr_prim) begin
      busy_q <= !empty;
      code_q <= reg_wdata_i[3:0];
    end else if (busy_q && empty) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (rd) begin
      unique case (ra)
        RA_REGST:  reg_rdata_o[1:0] = stat;
        RA_DONEST: reg_rdata_o[END_BIT] = end_flags[reg_mid_i];
        RA_PRIM:   reg_rdata_o = {busy_q, 27'd0, code_q};
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  a_r8_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_valid_o && !eng_done_i) |=> (eng_valid_o && $stable(eng_addr_o) &&
                                      $stable(eng_op_o) && $stable(eng_mid_o)));
  a_r11_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !empty && !wr_prim) |=> busy_q);
endmodule

// File: tb/tb_maint_queue.sv
module tb_maint_queue;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req = 0, we = 0, done = 0, stall = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata, v;
  logic [1:0] mid = 0;
  logic ev, ewh;
  logic [1:0] eop, emid;
  logic [31:0] ead, esz;
  int errs = 0, checks = 0;

  typedef struct packed {
    logic [1:0] op; logic wh; logic [31:0] a; logic [31:0] s; logic [1:0] m; logic nt;
  } ent_t;
  ent_t mq[$];

  maint_queue dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_mid_i(mid), .reg_rdata_o(rdata),
    .eng_valid_o(ev), .eng_op_o(eop), .eng_whole_o(ewh), .eng_addr_o(ead),
    .eng_size_o(esz), .eng_mid_o(emid), .eng_done_i(done)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // reference comparison on every clock (R8)
  always @(negedge clk) if (rst_n) begin
    chk("R8 valid", {31'd0, ev}, {31'd0, mq.size() != 0});
    if (ev && mq.size() != 0) begin
      chk("R8 op",    {30'd0, eop},  {30'd0, mq[0].op});
      chk("R8 whole", {31'd0, ewh},  {31'd0, mq[0].wh});
      chk("R8 addr",  ead,           mq[0].a);
      chk("R8 size",  esz,           mq[0].s);
      chk("R8 mid",   {30'd0, emid}, {30'd0, mq[0].m});
    end
  end

  // engine stub
  always @(negedge clk) done <= rst_n && ev && !stall && !done;

  always @(posedge clk) if (rst_n && done && mq.size() > 0) void'(mq.pop_front());

  task automatic wr(input logic [1:0] m, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; mid = m; addr = a; wdata = d;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] m, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; mid = m; addr = a;
    #5 d = rdata;
    @(posedge clk); #1 req = 0;
  endtask

  function automatic logic [31:0] mode(input logic [1:0] op, input logic wh, input logic nt);
    return (wh ? 32'h0002_0000 : 32'd0) | (nt ? 32'h0000_8000 : 32'd0) | {30'd0, op};
  endfunction

  task automatic issue(input logic [1:0] m, input logic [1:0] op, input logic nt,
                       input logic [31:0] a, input logic [31:0] s, input logic ok, input string r);
    logic [31:0] x;
    wr(m, 3'd0, mode(op, 1'b0, nt));
    wr(m, 3'd1, a);
    wr(m, 3'd2, s);
    rd(m, 3'd3, x);
    chk(r, x, ok ? 32'd0 : 32'd2);
    if (ok) mq.push_back('{op: op, wh: 1'b0, a: a, s: s, m: m, nt: nt});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      if (mq.size() == 0 && !ev) break;
      @(posedge clk);
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R8 watchdog act=timeout exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    chk("R1 valid", {31'd0, ev}, 32'd0);
    rd(2'd0, 3'd3, v); chk("R1 regstat", v, 0);
    rd(2'd0, 3'd4, v); chk("R1 donestat", v, 0);
    rd(2'd0, 3'd5, v); chk("R1 prim", v, 0);

    // R2 R4 R9 R10: range flush with notify
    issue(2'd0, 2'd2, 1'b1, 32'h1000, 32'h40, 1'b1, "R4 accept");
    wait_idle();
    rd(2'd0, 3'd4, v); chk("R9 end set", v, 32'h4);
    rd(2'd1, 3'd4, v); chk("R9 other master", v, 0);
    wr(2'd0, 3'd4, 32'h0);
    rd(2'd0, 3'd4, v); chk("R10 write0 no effect", v, 32'h4);
    wr(2'd0, 3'd4, 32'h4);
    rd(2'd0, 3'd4, v); chk("R10 cleared", v, 0);

    // R3: contention
    wr(2'd0, 3'd0, mode(2'd0, 1'b0, 1'b0));
    wr(2'd1, 3'd0, mode(2'd1, 1'b0, 1'b1));
    wr(2'd1, 3'd1, 32'hdead);
    wr(2'd0, 3'd1, 32'h2000);
    wr(2'd0, 3'd2, 32'h80);
    rd(2'd1, 3'd3, v); chk("R3 fail flag", v, 32'h1);
    rd(2'd1, 3'd3, v); chk("R3 flag cleared", v, 0);
    rd(2'd0, 3'd3, v); chk("R3 owner kept", v, 0);
    mq.push_back('{op: 2'd0, wh: 1'b0, a: 32'h2000, s: 32'h80, m: 2'd0, nt: 1'b0});
    wait_idle();
    rd(2'd0, 3'd4, v); chk("R9 no notify", v, 0);

    // R6: overwrite pending
    wr(2'd2, 3'd0, mode(2'd0, 1'b0, 1'b0));
    wr(2'd2, 3'd0, mode(2'd1, 1'b0, 1'b1));
    wr(2'd2, 3'd1, 32'h3000);
    wr(2'd2, 3'd2, 32'h100);
    rd(2'd2, 3'd3, v); chk("R6 accept", v, 0);
    mq.push_back('{op: 2'd1, wh: 1'b0, a: 32'h3000, s: 32'h100, m: 2'd2, nt: 1'b1});
    wait_idle();
    rd(2'd2, 3'd4, v); chk("R6 single notify", v, 32'h4);

    // R7: whole cache ignores start/size
    wr(2'd3, 3'd0, mode(2'd2, 1'b1, 1'b0));
    wr(2'd3, 3'd1, 32'h5555);
    wr(2'd3, 3'd2, 32'h99);
    rd(2'd3, 3'd3, v); chk("R7 accept", v, 0);
    mq.push_back('{op: 2'd2, wh: 1'b1, a: 32'h0, s: 32'h0, m: 2'd3, nt: 1'b0});
    wait_idle();

    // R5 R8 R11: fill queue with engine stalled
    stall = 1;
    for (int i = 0; i < 4; i++)
      issue(2'(i), 2'(i % 3), 1'b0, 32'h4000 + 32'(i) * 32'h40, 32'h40, 1'b1, "R8 fill");
    issue(2'd1, 2'd1, 1'b0, 32'h9000, 32'h40, 1'b0, "R5 full reject");
    issue(2'd2, 2'd2, 1'b0, 32'h9100, 32'h40, 1'b0, "R5 released after reject");
    rd(2'd2, 3'd3, v); chk("R5 flag not sticky", v, 0);
    wr(2'd0, 3'd5, 32'h8);
    rd(2'd0, 3'd5, v); chk("R11 busy", v, 32'h8000_0008);
    wr(2'd0, 3'd5, 32'h3);
    rd(2'd0, 3'd5, v); chk("R11 other code ignored", v, 32'h8000_0008);
    @(negedge clk); stall = 0;
    wait_idle();
    rd(2'd0, 3'd5, v); chk("R11 drained", v, 32'h8);
    wr(2'd1, 3'd5, 32'h9);
    rd(2'd1, 3'd5, v); chk("R11 pf flush idle", v, 32'h9);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule